// File: doc/BRIEF.md
# Dual-Carrier Four-Switch Buck-Boost Gate Generator

This block drives the gates of several bidirectional four-switch buck-boost legs that sit on one shared DC bus. Each leg has an input-side half-bridge (high and low switch, facing the storage device) and an output-side half-bridge (high and low switch, facing the bus). One up/down counter forms a triangle carrier that all legs share. For each leg, the top bit of its duty word picks a mode. In boost mode only the output-side half-bridge switches at the carrier rate. In buck mode only the input-side half-bridge switches. The half-bridge that does not switch is held in a fixed state. As a result, only two of the four switches in a leg commutate at high frequency.

The upper half of the duty range is mapped onto the same carrier as the lower half, so the two halves act as two stacked carriers whose switching ranges never overlap. Duty words are taken in only at the carrier valley, which keeps a period free of glitches. A per-leg enable and a global kill input force the affected gates off within one clock. Dead time, duty computation and sensing are handled outside this block.

Top module: `bbpwm_dual_carrier`

## Requirements
- R1: While `rst` is high, every gate output is low on each clock.
- R2: The carrier counts 0 up to HALF and back down, so one period is 2*HALF clocks (HALF defaults to 2500, giving 20 kHz from a 100 MHz clock). Let p = duty[14:0] and T = floor(p*HALF/32768). The modulated switch of an active leg is on while the carrier is below T. That gives 2T-1 on-clocks per period when T is at least 1, and 0 when T is 0.
- R3: Boost mode is duty[15]=0. The input high gate is held on, the input low gate is held off, the output high gate is modulated, and the output low gate is its exact complement.
- R4: Buck mode is duty[15]=1 (0x8000 means 0.5). The output high gate is held on, the output low gate is held off, the input high gate is modulated, and the input low gate is its exact complement.
- R5: A leg samples its duty word only at the carrier valley. A change between two valleys has no effect on the gates until the next valley.
- R6: While `kill_i` is high, all gates of all legs are low, starting one clock after it is seen.
- R7: A low `leg_en_i` bit forces the four gates of that leg low and leaves the other legs unaffected.
- R8: All legs share one carrier. Each leg follows its own duty word, so legs in different modes run at the same time.
- R9: Within a half-bridge, the high and low gates are never on in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_i | input | 32 | Duty words, 16 bits per leg; leg k occupies bits [16k+15:16k] |
| leg_en_i | input | 2 | Per-leg run enable |
| kill_i | input | 1 | Global disable, forces every gate off |
| gate_o | output | 8 | Gates; leg k uses bits 4k (input high), 4k+1 (input low), 4k+2 (output high), 4k+3 (output low) |

## Verification
The hardest case to reach from the ports is a duty change that lands strictly between two valleys, because the carrier phase is not visible at the ports. The bench recovers the phase from the falling edge of a modulated gate, which marks the carrier crossing the threshold on its rising ramp. It then raises the duty for a window that ends before the next valley, and checks that the gate stays low throughout. Mode boundaries at 0x0000, 0x7FFF, 0x8000 and 0xFFFF are checked by counting on-clocks over whole periods, and the complement and static pins are checked on every clock.

// File: rtl/bbpwm_pkg.sv
package bbpwm_pkg;

  typedef enum logic {
    MODE_BOOST = 1'b0,
    MODE_BUCK  = 1'b1
  } leg_mode_e;

  // bit0 = input-side high, bit1 = input-side low,
  // bit2 = output-side high, bit3 = output-side low
  typedef struct packed {
    logic out_lo;
    logic out_hi;
    logic in_lo;
    logic in_hi;
  } leg_gates_t;

endpackage

// File: rtl/bbpwm_carrier.sv
module bbpwm_carrier #(
  parameter int HALF = 2500,
  parameter int CW   = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] level_o,
  output logic          valley_o
);

  localparam logic [CW-1:0] TOP = CW'(HALF);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic rising_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o  <= '0;
      rising_q <= 1'b1;
    end else if (rising_q) begin
      level_o <= level_o + ONE;
      if (level_o == TOP - ONE) rising_q <= 1'b0;
    end else begin
      level_o <= level_o - ONE;
      if (level_o == ONE) rising_q <= 1'b1;
    end
  end

  assign valley_o = (level_o == '0);

  // R2: the ramp never leaves 0..HALF
  p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
    level_o <= TOP);

  // R2: the valley is always followed by the first rising step
  p_valley_turn_r2: assert property (@(posedge clk) disable iff (rst)
    valley_o |=> (level_o == ONE));

  // R2: the peak is always followed by a falling step
  p_peak_turn_r2: assert property (@(posedge clk) disable iff (rst)
    (level_o == TOP) |=> (level_o == TOP - ONE));

endmodule

// File: rtl/bbpwm_leg.sv
module bbpwm_leg
  import bbpwm_pkg::*;
#(
  parameter int DUTY_W = 16,
  parameter int HALF   = 2500,
  parameter int CW     = $clog2(HALF + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     level_i,
  input  logic              valley_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              en_i,
  input  logic              kill_i,
  output leg_gates_t        gates_o
);

  localparam int FW = DUTY_W - 1;
  localparam int PW = FW + CW;

  logic [PW-1:0] prod;
  logic [CW-1:0] thr_next;
  logic [CW-1:0] thr_q;
  leg_mode_e     mode_q;
  logic          mod_on;
  logic          active;
  leg_gates_t    gates_next;

  assign prod     = {{CW{1'b0}}, duty_i[FW-1:0]} * {{FW{1'b0}}, CW'(HALF)};
  assign thr_next = prod[PW-1:FW];
  assign mod_on   = (level_i < thr_q);
  assign active   = en_i && !kill_i;

  always_comb begin
    gates_next = '0;
    if (active) begin
      if (mode_q == MODE_BOOST) begin
        gates_next.in_hi  = 1'b1;
        gates_next.in_lo  = 1'b0;
        gates_next.out_hi = mod_on;
        gates_next.out_lo = !mod_on;
      end else begin
        gates_next.out_hi = 1'b1;
        gates_next.out_lo = 1'b0;
        gates_next.in_hi  = mod_on;
        gates_next.in_lo  = !mod_on;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q   <= '0;
      mode_q  <= MODE_BOOST;
      gates_o <= '0;
    end else begin
      if (valley_i) begin
        thr_q  <= thr_next;
        mode_q <= leg_mode_e'(duty_i[DUTY_W-1]);
      end
      gates_o <= gates_next;
    end
  end

  // R5: the latched duty only moves at a valley
  p_duty_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !valley_i |=> ($stable(thr_q) && $stable(mode_q)));

  // R6/R7: a disabled leg is dark on the next clock
  p_off_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !active |=> (gates_o == '0));

  // R3: boost keeps the input half-bridge static
  p_boost_static_r3: assert property (@(posedge clk) disable iff (rst)
    (active && mode_q == MODE_BOOST) |=> (gates_o.in_hi && !gates_o.in_lo));

  // R4: buck keeps the output half-bridge static
  p_buck_static_r4: assert property (@(posedge clk) disable iff (rst)
    (active && mode_q == MODE_BUCK) |=> (gates_o.out_hi && !gates_o.out_lo));

  // R9: no half-bridge shoot-through
  p_no_shoot_r9: assert property (@(posedge clk) disable iff (rst)
    !(gates_o.in_hi && gates_o.in_lo) && !(gates_o.out_hi && gates_o.out_lo));

endmodule

// File: rtl/bbpwm_dual_carrier.sv
module bbpwm_dual_carrier
  import bbpwm_pkg::*;
#(
  parameter int NUM_LEGS = 2,
  parameter int DUTY_W   = 16,
  parameter int HALF     = 2500
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LEGS*DUTY_W-1:0] duty_i,
  input  logic [NUM_LEGS-1:0]        leg_en_i,
  input  logic                       kill_i,
  output logic [4*NUM_LEGS-1:0]      gate_o
);

  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] level;
  logic          valley;

  bbpwm_carrier #(.HALF(HALF), .CW(CW)) u_carrier (
    .clk      (clk),
    .rst      (rst),
    .level_o  (level),
    .valley_o (valley)
  );

  for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
    leg_gates_t gl;

    bbpwm_leg #(.DUTY_W(DUTY_W), .HALF(HALF), .CW(CW)) u_leg (
      .clk      (clk),
      .rst      (rst),
      .level_i  (level),
      .valley_i (valley),
      .duty_i   (duty_i[k*DUTY_W +: DUTY_W]),
      .en_i     (leg_en_i[k]),
      .kill_i   (kill_i),
      .gates_o  (gl)
    );

    assign gate_o[4*k +: 4] = gl;
  end

  // R1: reset leaves every gate dark on the next clock
  p_reset_dark_r1: assert property (@(posedge clk)
    rst |=> (gate_o == '0));

endmodule

// File: tb/sim_bbpwm_dual_carrier.sv
`timescale 1ns/1ps
module sim_bbpwm_dual_carrier;

  localparam int HALF = 50;
  localparam int PER  = 2 * HALF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] duty = '0;
  logic [1:0]  en = 2'b11;
  logic        kill = 1'b0;
  logic [7:0]  gate;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bbpwm_dual_carrier #(.NUM_LEGS(2), .DUTY_W(16), .HALF(HALF)) u0 (
    .clk(clk), .rst(rst), .duty_i(duty), .leg_en_i(en), .kill_i(kill), .gate_o(gate)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_on(input logic [15:0] d);
    int t;
    t = (int'(d[14:0]) * HALF) >>> 15;
    return (t == 0) ? 0 : 2 * t - 1;
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count every gate over one full period and check pairs on each clock
  task automatic measure(output int cnt[8], output int shoot, output int cmp_err[2]);
    for (int g = 0; g < 8; g++) cnt[g] = 0;
    shoot = 0; cmp_err[0] = 0; cmp_err[1] = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      for (int g = 0; g < 8; g++) cnt[g] += int'(gate[g]);
      for (int l = 0; l < 2; l++) begin
        if ((gate[4*l] && gate[4*l+1]) || (gate[4*l+2] && gate[4*l+3])) shoot++;
        if (en[l] && !kill) begin
          if (gate[4*l+2] == gate[4*l+3] && !duty[16*l+15]) cmp_err[l]++;
          if (gate[4*l] == gate[4*l+1] && duty[16*l+15]) cmp_err[l]++;
        end
      end
    end
  endtask

  task automatic run_pattern(input logic [15:0] d0, input logic [15:0] d1, input string tag);
    int cnt[8];
    int shoot;
    int ce[2];
    logic [15:0] dl;
    duty = {d1, d0};
    cycles(2 * PER + 2);
    measure(cnt, shoot, ce);
    chk(shoot == 0, {"R9 ", tag}, shoot, 0);
    for (int l = 0; l < 2; l++) begin
      dl = (l == 0) ? d0 : d1;
      if (!en[l]) begin
        chk(cnt[4*l] + cnt[4*l+1] + cnt[4*l+2] + cnt[4*l+3] == 0, {"R7 leg off ", tag},
            cnt[4*l] + cnt[4*l+1] + cnt[4*l+2] + cnt[4*l+3], 0);
      end else if (!dl[15]) begin
        chk(cnt[4*l] == PER && cnt[4*l+1] == 0, {"R3 static ", tag}, cnt[4*l+1], 0);
        chk(cnt[4*l+2] == exp_on(dl), {"R2 boost count ", tag}, cnt[4*l+2], exp_on(dl));
        chk(ce[l] == 0, {"R3 complement ", tag}, ce[l], 0);
      end else begin
        chk(cnt[4*l+2] == PER && cnt[4*l+3] == 0, {"R4 static ", tag}, cnt[4*l+3], 0);
        chk(cnt[4*l] == exp_on(dl), {"R2 buck count ", tag}, cnt[4*l], exp_on(dl));
        chk(ce[l] == 0, {"R4 complement ", tag}, ce[l], 0);
      end
    end
  endtask

  task automatic test_reset;
    int hi = 0;
    duty = {16'hC000, 16'h4000};
    rst = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      hi += $countones(gate);
    end
    chk(hi == 0, "R1 gates during reset", hi, 0);
    rst = 1'b0;
  endtask

  task automatic test_midperiod;
    int hi = 0;
    duty = {16'h0000, 16'h199A};  // leg0 threshold 10
    cycles(2 * PER + 2);
    while (gate[2] !== 1'b1) @(negedge clk);
    while (gate[2] !== 1'b0) @(negedge clk);
    duty[15:0] = 16'h7FFF;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      hi += int'(gate[2]);
    end
    duty[15:0] = 16'h199A;
    chk(hi == 0, "R5 mid-period duty change ignored", hi, 0);
    run_pattern(16'h199A, 16'h0000, "after glitch");
  endtask

  task automatic test_kill;
    int hi = 0;
    duty = {16'hC000, 16'h4000};
    cycles(2 * PER);
    kill = 1'b1;
    cycles(2);
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      hi += $countones(gate);
    end
    chk(hi == 0, "R6 kill forces all off", hi, 0);
    kill = 1'b0;
    run_pattern(16'h4000, 16'hC000, "R6 resume");
  endtask

  task automatic test_leg_enable;
    en = 2'b10;
    run_pattern(16'h4000, 16'hA000, "R7 leg0 disabled");
    en = 2'b11;
  endtask

  initial begin
    test_reset();
    run_pattern(16'h4000, 16'hC000, "R8 mixed modes");
    run_pattern(16'h0000, 16'hFFFF, "zero and full");
    run_pattern(16'h7FFF, 16'h8000, "mode boundary");
    run_pattern(16'h1234, 16'h1234, "equal duties");
    test_midperiod();
    test_kill();
    test_leg_enable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(8 * 150000);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule